// File: doc/BRIEF.md
# FAT16 Root Directory Name Scanner

The scanner searches a FAT16 root directory for one file. The host pulses `start` and supplies two values: an 11-byte name in space-padded 8.3 form, and the number of slots in the root directory. The host then streams the directory sector by sector, one byte per cycle, with `in_valid` high for each byte. The block treats the stream as 32-byte records, so a 512-byte sector holds 16 of them.

Each name byte is compared with the target as it arrives. A sticky mismatch flag is kept for the current record, so no record buffer is needed. The block skips records that are deleted or that are volume labels. It stops with a miss on the end-of-directory marker, or when it has examined as many records as the slot count. When a sector has been consumed with no result, the host signals sector-complete and the block asks for the next sector. A hit reports the starting cluster and the byte length of the file. Both values and the hit or miss status are held until the next `start`.

The controller has five states:
- `ST_IDLE`: after reset.
- `ST_SCAN`: consuming records.
- `ST_REQ`: a one-cycle next-sector request.
- `ST_HIT`: match found.
- `ST_MISS`: not found.

Its transitions are:
- launch: any state to `ST_SCAN` on `start`, or to `ST_MISS` when the count is zero.
- end-mark: `ST_SCAN` to `ST_MISS`.
- limit: `ST_SCAN` to `ST_MISS`.
- match: `ST_SCAN` to `ST_HIT`.
- refill: `ST_SCAN` to `ST_REQ`.
- resume: `ST_REQ` to `ST_SCAN`.

Top module: `fat_dir_scan`

## Requirements
- R1: A `start` pulse latches `target_name` and `root_entries`, clears `first_cluster` and `file_size` to zero, and makes `busy` high in the next cycle. If `root_entries` is zero, the block goes to not-found instead: `not_found` is high in the next cycle.
- R2: Each record is 32 accepted bytes. Record bytes 0 to 10 are compared with target bytes 0 to 10, where target byte k is `target_name[8k+7:8k]`. All 11 must be equal for a match.
- R3: If byte 0 of a record is 0x00, the scan ends and `not_found` is high in the cycle after that byte.
- R4: A record whose byte 0 is 0xE5 is deleted and never matches, even if its other bytes equal the target. It still counts as examined.
- R5: A record whose byte 11 has bit 3 set is a volume label and never matches. It still counts as examined.
- R6: When the last byte (byte 31) of a matching record is accepted, `found` is high in the next cycle. At the same time:
  - `first_cluster` equals bytes 26 (low) and 27 (high) of that record.
  - `file_size` equals bytes 28 (lowest) to 31 (highest).
- R7: When the number of examined records reaches `root_entries` without a match, `not_found` is high in the cycle after the last byte of that record.
- R8: If `sector_done` is high while scanning and no result is reached in that cycle, `sector_req` is high for exactly one cycle, in the next cycle. `busy` stays high throughout.
- R9: If a result is reached in the same cycle as `sector_done`, the result wins and no `sector_req` is raised.
- R10: Bytes are ignored when `in_valid` is low, and when the block is not scanning. In the hit or miss state, the status, `first_cluster` and `file_size` stay unchanged until the next `start`.
- R11: A `start` during a scan abandons it. Any partially received record is discarded, and a new scan begins at record byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new search (pulse) |
| target_name | input | 88 | Space-padded 8.3 name, byte k at bits 8k+7:8k |
| root_entries | input | 16 | Number of root directory slots |
| in_valid | input | 1 | `in_byte` carries a directory byte |
| in_byte | input | 8 | Directory stream byte |
| sector_done | input | 1 | Current sector fully delivered (pulse) |
| sector_req | output | 1 | One-cycle request for the next sector |
| busy | output | 1 | Search in progress |
| found | output | 1 | Target located (held) |
| not_found | output | 1 | Search ended without a match (held) |
| first_cluster | output | 16 | Starting cluster of the located file |
| file_size | output | 32 | Byte length of the located file |

## Verification
Two events can land on the same clock edge: the decision on a record's last byte (a match, the end marker or the slot limit), and the host's sector-complete pulse. The bench provokes this by raising `sector_done` together with byte 31 of a matching 16th record. The reference model gives the decision priority, so `found` must rise and no `sector_req` may appear. The opposite case is also exercised: `sector_done` arrives alone after 16 non-matching records, and exactly one request pulse must follow.

// File: rtl/fds_pkg.sv
package fds_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_REQ,
        ST_HIT,
        ST_MISS
    } scan_state_t;

    localparam logic [7:0] MARK_END  = 8'h00;
    localparam logic [7:0] MARK_DEL  = 8'hE5;
    localparam int         ATTR_OFF  = 11;
    localparam int         LABEL_BIT = 3;
    localparam int         CLUS_OFF  = 26;
    localparam int         SIZE_OFF  = 28;
endpackage

// File: rtl/fds_entry_ctr.sv
module fds_entry_ctr #(
    parameter int ENTRY_BYTES = 32,
    parameter int CNT_W       = 16,
    localparam int OFF_W      = $clog2(ENTRY_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [OFF_W-1:0] off,
    output logic             last,
    output logic [CNT_W-1:0] done_cnt
);
    assign last = (off == OFF_W'(ENTRY_BYTES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off      <= '0;
            done_cnt <= '0;
        end else if (clear) begin
            off      <= '0;
            done_cnt <= '0;
        end else if (step) begin
            off <= last ? '0 : off + 1'b1;
            if (last) done_cnt <= done_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fds_name_cmp.sv
module fds_name_cmp #(
    parameter int NAME_LEN = 11,
    parameter int OFF_W    = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step,
    input  logic [OFF_W-1:0]      off,
    input  logic [7:0]            din,
    input  logic [NAME_LEN*8-1:0] target,
    output logic                  name_ok
);
    logic       mis_q;
    logic       in_name;
    logic [7:0] tbyte;
    int         sel;

    always_comb begin
        in_name = int'(off) < NAME_LEN;
        sel     = in_name ? int'(off) : 0;
        tbyte   = target[sel*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mis_q <= 1'b1;
        end else if (step) begin
            if (off == '0)
                mis_q <= (din != tbyte);
            else if (in_name)
                mis_q <= mis_q | (din != tbyte);
        end
    end

    assign name_ok = !mis_q;
endmodule

// File: rtl/fds_field_cap.sv
module fds_field_cap
    import fds_pkg::*;
#(
    parameter int OFF_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [OFF_W-1:0] off,
    input  logic [7:0]       din,
    output logic             deleted,
    output logic             label,
    output logic [15:0]      cluster,
    output logic [23:0]      size_lo
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            deleted <= 1'b0;
            label   <= 1'b0;
            cluster <= '0;
            size_lo <= '0;
        end else if (step) begin
            unique case (int'(off))
                0:            deleted       <= (din == MARK_DEL);
                ATTR_OFF:     label         <= din[LABEL_BIT];
                CLUS_OFF:     cluster[7:0]  <= din;
                CLUS_OFF + 1: cluster[15:8] <= din;
                SIZE_OFF:     size_lo[7:0]  <= din;
                SIZE_OFF + 1: size_lo[15:8] <= din;
                SIZE_OFF + 2: size_lo[23:16] <= din;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fat_dir_scan.sv
module fat_dir_scan
    import fds_pkg::*;
#(
    parameter int NAME_LEN    = 11,
    parameter int ENTRY_BYTES = 32,
    parameter int CNT_W       = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [NAME_LEN*8-1:0] target_name,
    input  logic [CNT_W-1:0]      root_entries,
    input  logic                  in_valid,
    input  logic [7:0]            in_byte,
    input  logic                  sector_done,
    output logic                  sector_req,
    output logic                  busy,
    output logic                  found,
    output logic                  not_found,
    output logic [15:0]           first_cluster,
    output logic [31:0]           file_size
);
    localparam int OFF_W = $clog2(ENTRY_BYTES);

    scan_state_t           state_q, state_d;
    logic [NAME_LEN*8-1:0] tgt_q;
    logic [CNT_W-1:0]      count_q;
    logic [15:0]           res_cluster;
    logic [31:0]           res_size;

    logic             accept;
    logic [OFF_W-1:0] off;
    logic             last;
    logic [CNT_W-1:0] done_cnt;
    logic             name_ok, deleted, label;
    logic [15:0]      cap_cluster;
    logic [23:0]      cap_size_lo;
    logic             end_mark, entry_end, hit_now, limit_now;

    assign accept = (state_q == ST_SCAN) && in_valid && !start;

    fds_entry_ctr #(.ENTRY_BYTES(ENTRY_BYTES), .CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clear(start), .step(accept),
        .off(off), .last(last), .done_cnt(done_cnt)
    );

    fds_name_cmp #(.NAME_LEN(NAME_LEN), .OFF_W(OFF_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .step(accept), .off(off),
        .din(in_byte), .target(tgt_q), .name_ok(name_ok)
    );

    fds_field_cap #(.OFF_W(OFF_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .step(accept), .off(off), .din(in_byte),
        .deleted(deleted), .label(label), .cluster(cap_cluster),
        .size_lo(cap_size_lo)
    );

    always_comb begin
        end_mark  = accept && (off == '0) && (in_byte == MARK_END);
        entry_end = accept && last;
        hit_now   = entry_end && name_ok && !deleted && !label;
        limit_now = entry_end && !hit_now &&
                    (({1'b0, done_cnt} + 1'b1) >= {1'b0, count_q});
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = (root_entries == '0) ? ST_MISS : ST_SCAN;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_HIT, ST_MISS: state_d = state_q;
                ST_REQ:  state_d = ST_SCAN;
                ST_SCAN: begin
                    if (end_mark || limit_now) state_d = ST_MISS;
                    else if (hit_now)          state_d = ST_HIT;
                    else if (sector_done)      state_d = ST_REQ;
                    else                       state_d = ST_SCAN;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state and context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            tgt_q       <= '0;
            count_q     <= '0;
            res_cluster <= '0;
            res_size    <= '0;
        end else begin
            state_q <= state_d;
            if (start) begin
                tgt_q       <= target_name;
                count_q     <= root_entries;
                res_cluster <= '0;
                res_size    <= '0;
            end else if (hit_now) begin
                res_cluster <= cap_cluster;
                res_size    <= {in_byte, cap_size_lo};
            end
        end
    end

    // outputs
    always_comb begin
        sector_req    = 1'b0;
        busy          = 1'b0;
        found         = 1'b0;
        not_found     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SCAN: busy = 1'b1;
            ST_REQ:  begin busy = 1'b1; sector_req = 1'b1; end
            ST_HIT:  found = 1'b1;
            ST_MISS: not_found = 1'b1;
            default: ;
        endcase
        first_cluster = res_cluster;
        file_size     = res_size;
    end
endmodule

// File: rtl/fat_dir_scan_chk.sv
module fat_dir_scan_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             sector_done,
    input logic [CNT_W-1:0] root_entries,
    input logic             sector_req,
    input logic             found,
    input logic             not_found,
    input logic [15:0]      first_cluster,
    input logic [31:0]      file_size
);
    p_status_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({found, not_found, sector_req}));

    p_req_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sector_req |=> !sector_req);

    p_req_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sector_req |-> $past(sector_done));

    p_hit_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (found && !start) |=> (found && $stable(first_cluster) && $stable(file_size)));

    p_miss_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (not_found && !start) |=> not_found);

    p_empty_dir_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && root_entries == '0) |=> not_found);
endmodule

bind fat_dir_scan fat_dir_scan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .sector_done(sector_done),
    .root_entries(root_entries), .sector_req(sector_req), .found(found),
    .not_found(not_found), .first_cluster(first_cluster), .file_size(file_size)
);

// File: tb/fat_dir_scan_tb.sv
`timescale 1ns/1ps
module fat_dir_scan_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [87:0] target_name = '0;
    logic [15:0] root_entries = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        sector_done = 1'b0;
    logic        sector_req, busy, found, not_found;
    logic [15:0] first_cluster;
    logic [31:0] file_size;

    int tests = 0;
    int fails = 0;
    int req_seen = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    fat_dir_scan u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .target_name(target_name),
        .root_entries(root_entries), .in_valid(in_valid), .in_byte(in_byte),
        .sector_done(sector_done), .sector_req(sector_req), .busy(busy),
        .found(found), .not_found(not_found), .first_cluster(first_cluster),
        .file_size(file_size)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model: 0 idle, 1 scan, 2 req, 3 hit, 4 miss
    int          m_st = 0;
    int          m_pos = 0;
    int          m_exam = 0;
    int          m_cnt = 0;
    logic [87:0] m_tgt = '0;
    logic [15:0] m_cl = '0;
    logic [31:0] m_sz = '0;
    logic [7:0]  ent [32];
    bit          decided;
    bit          nm;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_pos = 0; m_exam = 0; m_cl = '0; m_sz = '0;
        end else if (start) begin
            m_tgt = target_name; m_cnt = root_entries;
            m_pos = 0; m_exam = 0; m_cl = '0; m_sz = '0;
            m_st = (root_entries == 0) ? 4 : 1;
        end else if (m_st == 2) begin
            m_st = 1;
        end else if (m_st == 1) begin
            decided = 0;
            if (in_valid) begin
                ent[m_pos] = in_byte;
                if (m_pos == 0 && in_byte == 8'h00) begin
                    m_st = 4; decided = 1;
                end else if (m_pos == 31) begin
                    nm = 1;
                    for (int k = 0; k < 11; k++)
                        if (ent[k] != m_tgt[8*k +: 8]) nm = 0;
                    m_exam++; m_pos = 0;
                    if (nm && ent[0] != 8'hE5 && !ent[11][3]) begin
                        m_st = 3; decided = 1;
                        m_cl = {ent[27], ent[26]};
                        m_sz = {ent[31], ent[30], ent[29], ent[28]};
                    end else if (m_exam >= m_cnt) begin
                        m_st = 4; decided = 1;
                    end
                end else begin
                    m_pos++;
                end
            end
            if (!decided && sector_done) m_st = 2;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R6 found", found, m_st == 3);
            chk("R7 not_found", not_found, m_st == 4);
            chk("R8 sector_req", sector_req, m_st == 2);
            chk("R1 busy", busy, m_st == 1 || m_st == 2);
            chk("R6 first_cluster", first_cluster, m_cl);
            chk("R6 file_size", file_size, m_sz);
            if (sector_req) req_seen++;
        end
    end

    // stimulus helpers
    logic [7:0] q[$];

    function automatic logic [87:0] pack_name(input string s);
        logic [87:0] r;
        for (int k = 0; k < 11; k++) r[8*k +: 8] = s[k];
        return r;
    endfunction

    task automatic push_entry(input logic [87:0] nm_in, input logic [7:0] first,
                              input bit use_first, input logic [7:0] attr,
                              input logic [15:0] cl, input logic [31:0] sz);
        for (int k = 0; k < 32; k++) begin
            logic [7:0] b;
            b = 8'h00;
            if (k < 11) b = nm_in[8*k +: 8];
            if (k == 0 && use_first) b = first;
            if (k == 11) b = attr;
            if (k == 26) b = cl[7:0];
            if (k == 27) b = cl[15:8];
            if (k >= 28) b = sz[8*(k-28) +: 8];
            q.push_back(b);
        end
    endtask

    task automatic push_plain(input string s, input logic [15:0] cl);
        push_entry(pack_name(s), 8'h00, 0, 8'h20, cl, 32'h100 + cl);
    endtask

    task automatic send(input bit done_on_last, input bit gaps);
        int n;
        n = 0;
        while (q.size() > 0) begin
            @(negedge clk);
            if (gaps && (n % 5) == 4) begin
                in_valid = 1'b0; sector_done = 1'b0;
            end else begin
                in_byte = q.pop_front(); in_valid = 1'b1;
                sector_done = done_on_last && (q.size() == 0);
            end
            n++;
        end
        @(negedge clk);
        in_valid = 1'b0; sector_done = 1'b0;
    endtask

    task automatic do_start(input string s, input logic [15:0] cnt);
        @(negedge clk);
        start = 1'b1; target_name = pack_name(s); root_entries = cnt;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1;
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int r0;
        idle(3);
        chk("R1 reset found", found, 0);
        chk("R1 reset not_found", not_found, 0);
        chk("R1 reset busy", busy, 0);
        rst_n = 1'b1;
        idle(2);

        // deleted, label, near miss, then match (R2 R4 R5 R6)
        do_start("README  TXT", 16);
        chk("R1 busy after start", busy, 1);
        push_entry(pack_name("README  TXT"), 8'hE5, 1, 8'h20, 16'h0011, 32'h11);
        push_entry(pack_name("README  TXT"), 8'h00, 0, 8'h08, 16'h0022, 32'h22);
        push_entry(pack_name("README  TXX"), 8'h00, 0, 8'h20, 16'h0033, 32'h33);
        push_entry(pack_name("README  TXT"), 8'h00, 0, 8'h20, 16'h1234, 32'h00ABCDEF);
        send(0, 0);
        chk("R4 R5 R2 skipped to right record", first_cluster, 16'h1234);
        chk("R6 file_size", file_size, 32'h00ABCDEF);
        chk("R6 found", found, 1);
        // extra bytes after the hit are ignored (R10)
        push_plain("OTHER   BIN", 16'h0777);
        send(0, 0);
        chk("R10 held cluster", first_cluster, 16'h1234);
        chk("R10 held found", found, 1);

        // end marker (R3)
        do_start("BOOT    CFG", 512);
        push_plain("KERNEL  BIN", 16'h0005);
        for (int k = 0; k < 32; k++) q.push_back(8'h00);
        push_entry(pack_name("BOOT    CFG"), 8'h00, 0, 8'h20, 16'h0009, 32'h9);
        send(0, 0);
        chk("R3 end marker not_found", not_found, 1);
        chk("R3 no cluster", first_cluster, 0);

        // count limit (R7), later match ignored (R10)
        do_start("BOOT    CFG", 3);
        push_plain("A       TXT", 16'h0002);
        push_plain("B       TXT", 16'h0003);
        push_plain("C       TXT", 16'h0004);
        push_entry(pack_name("BOOT    CFG"), 8'h00, 0, 8'h20, 16'h0008, 32'h8);
        send(0, 0);
        chk("R7 limit not_found", not_found, 1);
        chk("R10 found stays low", found, 0);

        // two sectors with gaps (R8)
        do_start("DATA    BIN", 40);
        for (int e = 0; e < 16; e++) push_plain("FILLER  DAT", 16'(e + 2));
        send(0, 1);
        r0 = req_seen;
        @(negedge clk); sector_done = 1'b1;
        @(negedge clk); sector_done = 1'b0;
        chk("R8 request raised", sector_req, 1);
        chk("R8 busy during request", busy, 1);
        @(negedge clk);
        chk("R8 one request", req_seen - r0, 1);
        push_plain("FILLER  DAT", 16'h0040);
        push_entry(pack_name("DATA    BIN"), 8'h00, 0, 8'h21, 16'hFFF0, 32'h12345678);
        send(0, 1);
        chk("R8 second sector cluster", first_cluster, 16'hFFF0);
        chk("R6 second sector size", file_size, 32'h12345678);

        // sector_done with the deciding byte (R9)
        do_start("LAST    ONE", 40);
        for (int e = 0; e < 15; e++) push_plain("FILLER  DAT", 16'(e + 2));
        push_entry(pack_name("LAST    ONE"), 8'h00, 0, 8'h20, 16'h0ABC, 32'h4000);
        r0 = req_seen;
        send(1, 0);
        idle(2);
        chk("R9 result wins", found, 1);
        chk("R9 no request", req_seen - r0, 0);

        // zero slots (R1)
        do_start("ANY     TXT", 0);
        chk("R1 zero count not_found", not_found, 1);

        // restart mid-record (R11)
        do_start("FIRST   TXT", 40);
        push_entry(pack_name("FIRST   TXT"), 8'h00, 0, 8'h20, 16'h0101, 32'h1);
        for (int k = 0; k < 22; k++) void'(q.pop_back());
        send(0, 0);
        do_start("SECOND  TXT", 40);
        push_entry(pack_name("SECOND  TXT"), 8'h00, 0, 8'h20, 16'h0202, 32'h2);
        send(0, 0);
        chk("R11 restart cluster", first_cluster, 16'h0202);
        chk("R11 restart found", found, 1);

        idle(3);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule